// File: doc/BRIEF.md
# SDRAM mode register command decoder

This block sits on the device side of an SDRAM command bus. On every rising clock edge it looks at the registered control pins. It recognises a load of either the main or the extended mode register, and it decodes the programmed operating fields: burst length, burst ordering, CAS latency, test mode, DLL reset, DLL disable and output drive strength.

The block does more than copy the address bus into a register. It checks each load against the legal code subsets, the bits that must be zero, and the rule that every bank is precharged. It refuses a bad load and raises a sticky error. After each accepted load it holds a busy window of `MRD_CYCLES` clock cycles. A command that lands inside that window is refused and raises a separate sticky timing error. Both registers start undefined, so each one has its own valid flag.

Top module: `modereg_ctrl`

## Requirements
- R1: A register load is recognised only when `cke_i` is 1 and `cs_ni`, `ras_ni`, `cas_ni` and `we_ni` are all 0 at a rising clock edge. `ba_i[0]`=0 targets the main register and `ba_i[0]`=1 targets the extended register. If `cke_i` is 0 or `cs_ni` is 1, nothing changes.
- R2: In a main load, `addr_i[2:0]` codes 001, 010 and 011 set `burst_len_o` to 2, 4 and 8. `addr_i[3]` sets `burst_interleave_o` (0 sequential, 1 interleaved).
- R3: In a main load, `addr_i[6:4]` codes 010 and 011 set `cas_lat_o` to 2 and 3. `addr_i[8]` sets `dll_reset_o`.
- R4: A main load is illegal if any of the following holds: a burst length code other than 001/010/011; a latency code other than 010/011; any of `addr_i[11:9]` set; `ba_i[1]` set; or `addr_i[7]` set while `ALLOW_TEST_MODE`=0 (the default).
- R5: In an extended load, `addr_i[0]` sets `dll_off_o`. `{addr_i[6],addr_i[1]}` sets `drive_o`: 00 full, 01 weak, 11 matched. The code 10 is illegal, and so is any of `addr_i[5:2]`, `addr_i[11:7]` or `ba_i[1]` being set.
- R6: A load with `banks_idle_i`=0 is illegal.
- R7: An illegal load leaves every stored field unchanged and sets `err_illegal_o`. The flag stays set until reset.
- R8: `main_valid_o` and `ext_valid_o` are 0 from reset until the first legal load of their own register.
- R9: After an accepted load, `busy_o` is 1 for the next `MRD_CYCLES`-1 cycles (one cycle by default). A command at the first edge after the window is accepted.
- R10: Any command other than NOP (`cke_i`=1, `cs_ni`=0, not all of RAS/CAS/WE high) that arrives while `busy_o` is 1 sets the sticky `err_timing_o`. The command is ignored entirely: no field change and no `err_illegal_o`.
- R11: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| ba_i | input | 2 | Bank address; bit 0 selects the register |
| addr_i | input | 12 | Address bus carrying the register value |
| banks_idle_i | input | 1 | All banks precharged |
| burst_len_o | output | 4 | Burst length (2, 4 or 8) |
| burst_interleave_o | output | 1 | Interleaved burst order |
| cas_lat_o | output | 3 | CAS latency (2 or 3) |
| test_mode_o | output | 1 | Test mode bit |
| dll_reset_o | output | 1 | DLL reset request |
| main_valid_o | output | 1 | Main register written |
| dll_off_o | output | 1 | DLL disabled |
| drive_o | output | 2 | Drive strength code |
| ext_valid_o | output | 1 | Extended register written |
| busy_o | output | 1 | Post-load busy window |
| err_illegal_o | output | 1 | Sticky illegal-programming error |
| err_timing_o | output | 1 | Sticky busy-window violation |

## Verification
Two checks can fire on the same edge: the busy-window check and the validation of a load's contents. A malformed load issued one cycle after a legal load hits both. The bench expects the timing flag alone, with the illegal flag still low and the fields unchanged, because a refused command is never validated. It also places a load exactly on the first free edge and expects it to be accepted. This shows the window neither overruns nor restarts after a violation.

// File: rtl/modereg_pkg.sv
package modereg_pkg;
  typedef enum logic [1:0] {
    DRV_FULL    = 2'b00,
    DRV_WEAK    = 2'b01,
    DRV_MATCHED = 2'b11
  } drive_e;

  typedef struct packed {
    logic [3:0] burst_len;
    logic       interleave;
    logic [2:0] cas_lat;
    logic       test_mode;
    logic       dll_reset;
  } main_fields_t;

  typedef struct packed {
    logic   dll_off;
    drive_e drive;
  } ext_fields_t;
endpackage

// File: rtl/mr_cmd_decode.sv
module mr_cmd_decode (
  input  logic cke_i,
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  output logic is_cmd_o,
  output logic is_load_o
);
  logic selected;
  assign selected  = cke_i & ~cs_ni;
  assign is_cmd_o  = selected & ~(ras_ni & cas_ni & we_ni);
  assign is_load_o = selected & ~ras_ni & ~cas_ni & ~we_ni;
endmodule

// File: rtl/mr_busy_timer.sv
module mr_busy_timer #(
  parameter int MRD_CYCLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = (MRD_CYCLES < 2) ? 1 : $clog2(MRD_CYCLES);
  localparam logic [CW-1:0] LOAD = CW'(MRD_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (start_i)      cnt_q <= LOAD;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  generate
    if (MRD_CYCLES > 1) begin : g_chk
      // R9
      busy_after_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> busy_o);
    end
  endgenerate
endmodule

// File: rtl/mr_main_reg.sv
module mr_main_reg
  import modereg_pkg::*;
#(
  parameter bit ALLOW_TEST_MODE = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [11:0]  addr_i,
  input  logic         ba_hi_i,
  input  logic         idle_i,
  output main_fields_t fields_o,
  output logic         valid_o,
  output logic         illegal_o
);
  main_fields_t fields_q, fields_d;
  logic valid_q;
  logic bl_ok, cl_ok, tm_bad, mbz_bad, bad, legal_wr;
  logic [3:0] bl_val;
  logic [2:0] cl_val;

  always_comb begin
    bl_ok = 1'b1;
    case (addr_i[2:0])
      3'b001:  bl_val = 4'd2;
      3'b010:  bl_val = 4'd4;
      3'b011:  bl_val = 4'd8;
      default: begin bl_val = 4'd0; bl_ok = 1'b0; end
    endcase
  end

  always_comb begin
    cl_ok = 1'b1;
    case (addr_i[6:4])
      3'b010:  cl_val = 3'd2;
      3'b011:  cl_val = 3'd3;
      default: begin cl_val = 3'd0; cl_ok = 1'b0; end
    endcase
  end

  generate
    if (ALLOW_TEST_MODE) begin : g_tm_on
      assign tm_bad = 1'b0;
    end else begin : g_tm_off
      assign tm_bad = addr_i[7];
    end
  endgenerate

  assign mbz_bad   = |addr_i[11:9] | ba_hi_i;
  assign bad       = ~bl_ok | ~cl_ok | tm_bad | mbz_bad | ~idle_i;
  assign illegal_o = wr_i & bad;
  assign legal_wr  = wr_i & ~bad;

  always_comb begin
    fields_d.burst_len  = bl_val;
    fields_d.interleave = addr_i[3];
    fields_d.cas_lat    = cl_val;
    fields_d.test_mode  = addr_i[7];
    fields_d.dll_reset  = addr_i[8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fields_q <= '0;
      valid_q  <= 1'b0;
    end else if (legal_wr) begin
      fields_q <= fields_d;
      valid_q  <= 1'b1;
    end
  end

  assign fields_o = fields_q;
  assign valid_o  = valid_q;

  // R7
  main_hold_on_bad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> $stable(fields_o));
  // R8
  main_valid_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o);
  // R2
  main_bl_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legal_wr |=> (fields_o.burst_len == 4'd2 || fields_o.burst_len == 4'd4 ||
                  fields_o.burst_len == 4'd8));
  // R3
  main_cl_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legal_wr |=> (fields_o.cas_lat == 3'd2 || fields_o.cas_lat == 3'd3));
endmodule

// File: rtl/mr_ext_reg.sv
module mr_ext_reg
  import modereg_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [11:0] addr_i,
  input  logic        ba_hi_i,
  input  logic        idle_i,
  output ext_fields_t fields_o,
  output logic        valid_o,
  output logic        illegal_o
);
  ext_fields_t fields_q, fields_d;
  logic valid_q;
  logic [1:0] drv_code;
  logic drv_bad, mbz_bad, bad, legal_wr;

  assign drv_code  = {addr_i[6], addr_i[1]};
  assign drv_bad   = (drv_code == 2'b10);
  assign mbz_bad   = |addr_i[5:2] | |addr_i[11:7] | ba_hi_i;
  assign bad       = drv_bad | mbz_bad | ~idle_i;
  assign illegal_o = wr_i & bad;
  assign legal_wr  = wr_i & ~bad;

  always_comb begin
    fields_d.dll_off = addr_i[0];
    fields_d.drive   = drive_e'(drv_code);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fields_q <= '0;
      valid_q  <= 1'b0;
    end else if (legal_wr) begin
      fields_q <= fields_d;
      valid_q  <= 1'b1;
    end
  end

  assign fields_o = fields_q;
  assign valid_o  = valid_q;

  // R7
  ext_hold_on_bad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> $stable(fields_o));
  // R5
  ext_drive_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (fields_o.drive != 2'b10));
  // R8
  ext_valid_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o);
endmodule

// File: rtl/modereg_ctrl.sv
module modereg_ctrl
  import modereg_pkg::*;
#(
  parameter int MRD_CYCLES      = 2,
  parameter bit ALLOW_TEST_MODE = 1'b0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cke_i,
  input  logic        cs_ni,
  input  logic        ras_ni,
  input  logic        cas_ni,
  input  logic        we_ni,
  input  logic [1:0]  ba_i,
  input  logic [11:0] addr_i,
  input  logic        banks_idle_i,
  output logic [3:0]  burst_len_o,
  output logic        burst_interleave_o,
  output logic [2:0]  cas_lat_o,
  output logic        test_mode_o,
  output logic        dll_reset_o,
  output logic        main_valid_o,
  output logic        dll_off_o,
  output logic [1:0]  drive_o,
  output logic        ext_valid_o,
  output logic        busy_o,
  output logic        err_illegal_o,
  output logic        err_timing_o
);
  logic is_cmd, is_load, accept, main_wr, ext_wr;
  logic main_bad, ext_bad, start;
  logic err_ill_q, err_tim_q;
  main_fields_t main_f;
  ext_fields_t  ext_f;

  mr_cmd_decode i_dec (
    .cke_i(cke_i), .cs_ni(cs_ni), .ras_ni(ras_ni), .cas_ni(cas_ni), .we_ni(we_ni),
    .is_cmd_o(is_cmd), .is_load_o(is_load)
  );

  // a refused command is never validated
  assign accept  = is_load & ~busy_o;
  assign main_wr = accept & ~ba_i[0];
  assign ext_wr  = accept & ba_i[0];
  assign start   = accept & ~(main_bad | ext_bad);

  mr_main_reg #(.ALLOW_TEST_MODE(ALLOW_TEST_MODE)) i_main (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(main_wr), .addr_i(addr_i),
    .ba_hi_i(ba_i[1]), .idle_i(banks_idle_i),
    .fields_o(main_f), .valid_o(main_valid_o), .illegal_o(main_bad)
  );

  mr_ext_reg i_ext (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(ext_wr), .addr_i(addr_i),
    .ba_hi_i(ba_i[1]), .idle_i(banks_idle_i),
    .fields_o(ext_f), .valid_o(ext_valid_o), .illegal_o(ext_bad)
  );

  mr_busy_timer #(.MRD_CYCLES(MRD_CYCLES)) i_busy (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .busy_o(busy_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_ill_q <= 1'b0;
      err_tim_q <= 1'b0;
    end else begin
      if (main_bad | ext_bad) err_ill_q <= 1'b1;
      if (is_cmd & busy_o)    err_tim_q <= 1'b1;
    end
  end

  assign burst_len_o        = main_f.burst_len;
  assign burst_interleave_o = main_f.interleave;
  assign cas_lat_o          = main_f.cas_lat;
  assign test_mode_o        = main_f.test_mode;
  assign dll_reset_o        = main_f.dll_reset;
  assign dll_off_o          = ext_f.dll_off;
  assign drive_o            = ext_f.drive;
  assign err_illegal_o      = err_ill_q;
  assign err_timing_o       = err_tim_q;

  // R7
  illegal_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_illegal_o |=> err_illegal_o);
  // R10
  timing_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_timing_o |=> err_timing_o);
  // R10
  busy_cmd_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_cmd && busy_o) |=> (err_timing_o && $stable(main_f) && $stable(ext_f) &&
                            $stable(err_illegal_o)));
  // R1
  no_select_no_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_i || cs_ni) |=> ($stable(main_f) && $stable(ext_f) && $stable(err_illegal_o)));
endmodule

// File: tb/test_modereg_ctrl.sv
`timescale 1ns/1ps
module test_modereg_ctrl;
  logic clk = 1'b0;
  logic rst_ni, cke, cs_n, ras_n, cas_n, we_n, idle;
  logic [1:0] ba;
  logic [11:0] addr;
  logic [3:0] bl;
  logic bt, tm, dr, mv, doff, ev, busy, eill, etim;
  logic [2:0] cl;
  logic [1:0] drv;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  modereg_ctrl i_modereg_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .cke_i(cke), .cs_ni(cs_n), .ras_ni(ras_n),
    .cas_ni(cas_n), .we_ni(we_n), .ba_i(ba), .addr_i(addr), .banks_idle_i(idle),
    .burst_len_o(bl), .burst_interleave_o(bt), .cas_lat_o(cl), .test_mode_o(tm),
    .dll_reset_o(dr), .main_valid_o(mv), .dll_off_o(doff), .drive_o(drv),
    .ext_valid_o(ev), .busy_o(busy), .err_illegal_o(eill), .err_timing_o(etim)
  );

  // {ba[1:0], addr[11:0], idle, exp_illegal, exp_bl[3:0], exp_bt, exp_cl[2:0], exp_dllrst}
  localparam int NV = 10;
  localparam logic [24:0] VEC [NV] = '{
    {2'b00, 12'h031, 1'b1, 1'b0, 4'd2, 1'b0, 3'd3, 1'b0},  // R2 R3 BL2 seq CL3
    {2'b00, 12'h02B, 1'b1, 1'b0, 4'd8, 1'b1, 3'd2, 1'b0},  // R2 R3 BL8 interleaved CL2
    {2'b00, 12'h122, 1'b1, 1'b0, 4'd4, 1'b0, 3'd2, 1'b1},  // R3 DLL reset
    {2'b00, 12'h030, 1'b1, 1'b1, 4'd4, 1'b0, 3'd3, 1'b0},  // R4 BL code 000
    {2'b00, 12'h024, 1'b1, 1'b1, 4'd4, 1'b0, 3'd3, 1'b0},  // R4 BL code 100
    {2'b00, 12'h012, 1'b1, 1'b1, 4'd4, 1'b0, 3'd3, 1'b0},  // R4 CL code 001
    {2'b00, 12'h0B2, 1'b1, 1'b1, 4'd4, 1'b0, 3'd3, 1'b0},  // R4 test mode bit
    {2'b00, 12'h232, 1'b1, 1'b1, 4'd4, 1'b0, 3'd3, 1'b0},  // R4 A9 set
    {2'b10, 12'h031, 1'b1, 1'b1, 4'd4, 1'b0, 3'd3, 1'b0},  // R4 BA1 set
    {2'b00, 12'h031, 1'b0, 1'b1, 4'd4, 1'b0, 3'd3, 1'b0}   // R6 banks open
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic nop();
    cke = 1'b1; cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
    ba = 2'b00; addr = 12'h000; idle = 1'b1;
  endtask

  // drive at the current negedge, hold through one rising edge
  task automatic issue(input logic k, input logic c, input logic r, input logic a,
                       input logic w, input logic [1:0] b, input logic [11:0] ad,
                       input logic id);
    cke = k; cs_n = c; ras_n = r; cas_n = a; we_n = w; ba = b; addr = ad; idle = id;
    @(negedge clk);
    nop();
  endtask

  task automatic load(input logic [1:0] b, input logic [11:0] ad, input logic id);
    issue(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, b, ad, id);
  endtask

  task automatic do_reset();
    nop();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R11 R8 reset state
    check("R11 burst_len", int'(bl), 0);
    check("R11 cas_lat", int'(cl), 0);
    check("R11 drive", int'(drv), 0);
    check("R8 main_valid", int'(mv), 0);
    check("R8 ext_valid", int'(ev), 0);
    check("R11 flags", int'({busy, eill, etim}), 0);

    // R1 deselected or clock-disabled load has no effect
    issue(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 12'h032, 1'b1);
    check("R1 cke low valid", int'(mv), 0);
    issue(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 12'h032, 1'b1);
    check("R1 cs high valid", int'(mv), 0);
    check("R1 cs high busy", int'(busy), 0);

    // table walk: base load, then vector load one cycle after the window
    for (int i = 0; i < NV; i++) begin
      do_reset();
      load(2'b00, 12'h032, 1'b1);
      @(negedge clk);
      load(VEC[i][24:23], VEC[i][22:11], VEC[i][10]);
      check($sformatf("R7 vec%0d err_illegal", i), int'(eill), int'(VEC[i][9]));
      check($sformatf("R2 vec%0d burst_len", i), int'(bl), int'(VEC[i][8:5]));
      check($sformatf("R2 vec%0d interleave", i), int'(bt), int'(VEC[i][4]));
      check($sformatf("R3 vec%0d cas_lat", i), int'(cl), int'(VEC[i][3:1]));
      check($sformatf("R3 vec%0d dll_reset", i), int'(dr), int'(VEC[i][0]));
      check($sformatf("R8 vec%0d main_valid", i), int'(mv), 1);
      check($sformatf("R8 vec%0d ext_valid", i), int'(ev), 0);
    end

    // R5 extended register
    do_reset();
    load(2'b01, 12'h000, 1'b1);
    check("R5 ext valid", int'(ev), 1);
    check("R8 main untouched", int'(mv), 0);
    check("R5 dll on full", int'({doff, drv}), 0);
    @(negedge clk);
    load(2'b01, 12'h003, 1'b1);
    check("R5 dll off weak", int'({doff, drv}), 3'b101);
    @(negedge clk);
    load(2'b01, 12'h042, 1'b1);
    check("R5 matched", int'({doff, drv}), 3'b011);
    @(negedge clk);
    load(2'b01, 12'h040, 1'b1);
    check("R5 reserved drive err", int'(eill), 1);
    check("R7 ext unchanged", int'({doff, drv}), 3'b011);
    @(negedge clk);
    load(2'b01, 12'h010, 1'b1);
    check("R5 mbz unchanged", int'({doff, drv}), 3'b011);
    check("R7 sticky after legal", int'(eill), 1);

    // R9 R10 busy window
    do_reset();
    load(2'b00, 12'h032, 1'b1);
    check("R9 busy after load", int'(busy), 1);
    load(2'b00, 12'h02B, 1'b1);
    check("R10 timing flag", int'(etim), 1);
    check("R10 fields held", int'(bl), 4);
    check("R10 no illegal", int'(eill), 0);
    check("R9 busy ended", int'(busy), 0);
    load(2'b00, 12'h02B, 1'b1);
    check("R9 first free edge accepted", int'(bl), 8);
    check("R10 timing sticky", int'(etim), 1);

    // R10 malformed load inside window: timing only
    do_reset();
    load(2'b00, 12'h032, 1'b1);
    load(2'b00, 12'h030, 1'b0);
    check("R10 malformed in window timing", int'(etim), 1);
    check("R10 malformed in window illegal", int'(eill), 0);

    // R10 NOP in window is harmless, activate is not
    do_reset();
    load(2'b00, 12'h032, 1'b1);
    issue(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 12'h000, 1'b1);
    check("R10 deselect in window", int'(etim), 0);
    load(2'b00, 12'h032, 1'b1);
    issue(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2'b00, 12'h000, 1'b1);
    check("R10 activate in window", int'(etim), 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule